// File: doc/BRIEF.md
# Registered ROM with Dual Output Enables

A read-only store of 512 eight-bit words whose read data passes through an edge-triggered output register. The word at the address presented before a rising clock edge is captured on that edge and held until the next one. Between edges the address and the synchronous enable can change freely without any effect on the outputs. This lets the next location be looked up while the current word stays stable.

Two enables gate the outputs. The first is a synchronous enable, held in its own flip-flop. That flip-flop comes up disabled and takes the pin's value on each clock edge. The second is an asynchronous enable that switches the outputs off or on at once. The data register also has two active-low asynchronous loads: one forces all ones and the other forces all zeros. A drive flag stands in for tri-state, and the data bus reads zero whenever the flag is low.

Top module: `rrom_dual_en`

## Requirements
- R1: The array holds 512 words of 8 bits. The word at address a is (a mod 256) XOR 8'hA5 when a < 256, and (a mod 256) XOR 8'h3C otherwise.
- R2: On each rising clock edge the word at addr_i is loaded into the output register. A change of addr_i between edges leaves data_o unchanged until the next edge.
- R3: While rst_ni is low, the enable flip-flop is disabled and drive_o is 0. It stays disabled until a rising edge samples sen_ni low.
- R4: After a rising edge that samples sen_ni low, drive_o is 1 while aen_ni is low.
- R5: After a rising edge that samples sen_ni high, drive_o is 0 whatever aen_ni is. A change of sen_ni between edges has no effect until the next edge.
- R6: aen_ni high forces drive_o to 0 at once, with no clock. Returning aen_ni low restores drive_o at once if the registered enable is active.
- R7: preset_ni low loads all ones into the data register at once, independent of the clock and of addr_i.
- R8: clear_ni low with preset_ni high loads all zeros into the data register at once.
- R9: preset_ni and clear_ni both low gives all ones (preset wins).
- R10: data_o equals the register contents while drive_o is 1 and is all zeros while drive_o is 0. A value loaded by preset or clear appears only once the outputs are driven.
- R11: preset_ni and clear_ni do not change the enable flip-flop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock; rising edge captures data and enable |
| rst_ni | input | 1 | Active-low power-on reset of the enable flip-flop |
| addr_i | input | 9 | Word address |
| sen_ni | input | 1 | Synchronous enable, active low, sampled on the clock |
| aen_ni | input | 1 | Asynchronous enable, active low, acts at once |
| preset_ni | input | 1 | Active-low asynchronous all-ones load of the data register |
| clear_ni | input | 1 | Active-low asynchronous all-zeros load of the data register |
| data_o | output | 8 | Output word, zero while not driven |
| drive_o | output | 1 | High when the outputs are driven |

## Verification
Read data and the synchronous enable each take effect one register stage after their inputs. The bench therefore changes inputs on the falling edge and checks results 2 ns after the next rising edge. It also checks 1 ns after a mid-cycle input change to confirm that nothing has moved yet. The asynchronous enable, preset and clear act with no clock. Their effect is checked 1 ns after the pin moves, inside a half-period, so that no rising edge lies between stimulus and sample.

// File: rtl/rrom_pkg.sv
package rrom_pkg;
  localparam int unsigned ADDR_W  = 9;
  localparam int unsigned DATA_W  = 8;
  localparam logic [7:0]  SEED_LO = 8'hA5;
  localparam logic [7:0]  SEED_HI = 8'h3C;
endpackage

// File: rtl/rrom_array.sv
module rrom_array #(
  parameter int unsigned ADDR_W = rrom_pkg::ADDR_W,
  parameter int unsigned DATA_W = rrom_pkg::DATA_W
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [DATA_W-1:0] word_o
);
  localparam int unsigned DEPTH = 1 << ADDR_W;

  function automatic logic [DATA_W-1:0] fill(input int unsigned a);
    logic [DATA_W-1:0] seed;
    seed = ((a >> DATA_W) != 0) ? DATA_W'(rrom_pkg::SEED_HI) : DATA_W'(rrom_pkg::SEED_LO);
    return DATA_W'(a) ^ seed;
  endfunction

  logic [DATA_W-1:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    assign mem[i] = fill(i);
  end

  assign word_o = mem[addr_i];
endmodule

// File: rtl/rrom_data_reg.sv
module rrom_data_reg #(
  parameter int unsigned DATA_W = rrom_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              preset_ni,
  input  logic              clear_ni,
  input  logic [DATA_W-1:0] d_i,
  output logic [DATA_W-1:0] q_o
);
  // preset has priority over clear
  always_ff @(posedge clk_i or negedge preset_ni or negedge clear_ni) begin
    if (!preset_ni)     q_o <= '1;
    else if (!clear_ni) q_o <= '0;
    else                q_o <= d_i;
  end

  a_r7_preset_ones: assert property (@(posedge clk_i) !preset_ni |-> q_o == '1);
  a_r8_clear_zeros: assert property (@(posedge clk_i) (preset_ni && !clear_ni) |-> q_o == '0);
endmodule

// File: rtl/rrom_enable.sv
module rrom_enable (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sen_ni,
  output logic en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_o <= 1'b0;
    else         en_o <= !sen_ni;
  end

  a_r5_sync_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(sen_ni) |-> !en_o);
  a_r4_sync_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(sen_ni)) |-> en_o);
endmodule

// File: rtl/rrom_dual_en.sv
module rrom_dual_en #(
  parameter int unsigned ADDR_W = rrom_pkg::ADDR_W,
  parameter int unsigned DATA_W = rrom_pkg::DATA_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              sen_ni,
  input  logic              aen_ni,
  input  logic              preset_ni,
  input  logic              clear_ni,
  output logic [DATA_W-1:0] data_o,
  output logic              drive_o
);
  logic [DATA_W-1:0] word;
  logic [DATA_W-1:0] q;
  logic              en_q;

  rrom_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
    .addr_i (addr_i),
    .word_o (word)
  );

  rrom_data_reg #(.DATA_W(DATA_W)) u_reg (
    .clk_i     (clk_i),
    .preset_ni (preset_ni),
    .clear_ni  (clear_ni),
    .d_i       (word),
    .q_o       (q)
  );

  rrom_enable u_en (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sen_ni (sen_ni),
    .en_o   (en_q)
  );

  assign drive_o = en_q & !aen_ni;
  assign data_o  = drive_o ? q : '0;

  always_comb begin
    if (!rst_ni) a_r3_reset_off: assert (!drive_o);
  end

  a_r6_async_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aen_ni |-> !drive_o);
  a_r10_idle_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !drive_o |-> data_o == '0);
endmodule

// File: tb/tb_rrom_dual_en.sv
`timescale 1ns/1ps
module tb_rrom_dual_en;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [8:0] addr_i = '0;
  logic       sen_ni = 1'b1;
  logic       aen_ni = 1'b0;
  logic       preset_ni = 1'b1;
  logic       clear_ni = 1'b1;
  logic [7:0] data_o;
  logic       drive_o;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk_i = ~clk_i;

  rrom_dual_en dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .sen_ni(sen_ni),
    .aen_ni(aen_ni), .preset_ni(preset_ni), .clear_ni(clear_ni),
    .data_o(data_o), .drive_o(drive_o)
  );

  function automatic logic [7:0] expw(input int a);
    return 8'(a % 256) ^ ((a >= 256) ? 8'h3C : 8'hA5);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // drive at falling edge, sample 2 ns after the following rising edge
  task automatic cyc();
    @(posedge clk_i);
    #2;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    #3;
    chk("R3 reset drive", int'(drive_o), 0);
    chk("R3 reset data", int'(data_o), 0);
    cyc(); cyc();
    chk("R3 reset held over edges", int'(drive_o), 0);
    @(negedge clk_i); rst_ni = 1'b1;
    cyc();
    chk("R3 sen high keeps disabled", int'(drive_o), 0);
    chk("R10 idle data zero", int'(data_o), 0);

    // R1 R2 R4 full sweep
    @(negedge clk_i); sen_ni = 1'b0;
    for (int a = 0; a < 512; a++) begin
      @(negedge clk_i); addr_i = 9'(a);
      cyc();
      chk("R4 driven", int'(drive_o), 1);
      chk("R1 word", int'(data_o), int'(expw(a)));
    end
    // R2 address change between edges
    @(negedge clk_i); addr_i = 9'd3;
    cyc();
    @(negedge clk_i); addr_i = 9'd300;
    #1 chk("R2 no change before edge", int'(data_o), int'(expw(3)));
    cyc();
    chk("R2 captured at edge", int'(data_o), int'(expw(300)));

    // R6 async enable
    @(negedge clk_i); aen_ni = 1'b1;
    #1 chk("R6 async off", int'(drive_o), 0);
    chk("R10 data zero when off", int'(data_o), 0);
    aen_ni = 1'b0;
    #1 chk("R6 async on", int'(drive_o), 1);
    chk("R6 data back", int'(data_o), int'(expw(300)));

    // R5 sync disable
    @(negedge clk_i); sen_ni = 1'b1;
    #1 chk("R5 no effect before edge", int'(drive_o), 1);
    cyc();
    chk("R5 off after edge", int'(drive_o), 0);
    @(negedge clk_i); aen_ni = 1'b1; sen_ni = 1'b0;
    cyc();
    chk("R6 aen high overrides enable", int'(drive_o), 0);
    @(negedge clk_i); aen_ni = 1'b0;
    #1 chk("R4 on with both low", int'(drive_o), 1);

    // R7 R8 R9 async loads between edges
    @(negedge clk_i); addr_i = 9'd17;
    #1 preset_ni = 1'b0;
    #1 chk("R7 preset ones", int'(data_o), 8'hFF);
    preset_ni = 1'b1;
    #1 chk("R7 held after release", int'(data_o), 8'hFF);
    cyc();
    chk("R2 reload after preset", int'(data_o), int'(expw(17)));
    @(negedge clk_i);
    #1 clear_ni = 1'b0;
    #1 chk("R8 clear zeros", int'(data_o), 0);
    chk("R11 clear keeps enable", int'(drive_o), 1);
    clear_ni = 1'b1;
    @(negedge clk_i);
    #1 preset_ni = 1'b0; clear_ni = 1'b0;
    #1 chk("R9 preset wins", int'(data_o), 8'hFF);
    preset_ni = 1'b1; clear_ni = 1'b1;

    // R10 preset while undriven, R11 preset does not enable
    @(negedge clk_i); sen_ni = 1'b1;
    cyc();
    @(negedge clk_i);
    #1 preset_ni = 1'b0;
    #1 chk("R11 preset keeps disabled", int'(drive_o), 0);
    chk("R10 preset hidden", int'(data_o), 0);
    preset_ni = 1'b1;
    @(negedge clk_i); sen_ni = 1'b0; aen_ni = 1'b1;
    cyc();
    @(negedge clk_i);
    #1 preset_ni = 1'b0;
    #1 chk("R10 preset hidden by aen", int'(data_o), 0);
    preset_ni = 1'b1;
    aen_ni = 1'b0;
    #1 chk("R10 preset shown on enable", int'(data_o), 8'hFF);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule